// File: doc/BRIEF.md
# Workspace-Pointer Context Switch Unit

This unit performs vectored context switches for a processor whose sixteen general registers live in memory rather than in the core. The core keeps only three 16-bit registers: the program counter (PC), the status word (ST) and the workspace pointer (WP). WP holds the byte address of a block of sixteen 16-bit words, and register n sits at byte offset 2n from WP. A context switch does not push anything onto a stack. The unit reads a new WP and a new PC from a two-word vector. It then writes the old WP, PC and ST into registers 13, 14 and 15 of the new workspace and loads the new state. A return operation reverses this by reloading all three registers from registers 13 to 15 of the current workspace.

There are three sources of switches. The first is sixteen level-held hardware requests, gated by a 4-bit mask in ST and resolved by fixed priority. The second is a software branch request that carries a 4-bit vector number. The third is a return request. Memory is byte-addressed over 64 KiB and big-endian, and it is reached as 32K 16-bit words through a single port. That port has a fixed one-cycle read latency.

The sequencer has eleven states:
- `S_IDLE` waits for and arbitrates requests.
- `S_VEC_WP` and `S_VEC_PC` read the vector words.
- `S_SAVE_WP`, `S_SAVE_PC` and `S_SAVE_ST` write the old state.
- `S_RET_WP`, `S_RET_PC`, `S_RET_ST` and `S_RET_LAST` read the saved state back.
- `S_COMMIT` loads the new registers and pulses the acknowledge.

The transitions are:
- A hardware or software request takes `S_IDLE` to `S_VEC_WP`.
- The switch path then runs `S_VEC_WP`, `S_VEC_PC`, `S_SAVE_WP`, `S_SAVE_PC`, `S_SAVE_ST` and `S_COMMIT` in order.
- A return request takes `S_IDLE` to `S_RET_WP`.
- The return path then runs `S_RET_WP`, `S_RET_PC`, `S_RET_ST`, `S_RET_LAST` and `S_COMMIT` in order.
- `S_COMMIT` always goes back to `S_IDLE`.

Top module: `ctx_switch_unit`

## Requirements
- R1: After reset PC, ST and WP are all zero. No acknowledge is asserted and `mem_req` stays low until a request arrives.
- R2: A hardware switch for level L reads the new WP from byte address 4L and then the new PC from byte address 4L+2. After the switch, WP and PC hold those two words.
- R3: Every switch writes the old WP, the old PC and the old ST to byte addresses newWP+26, newWP+28 and newWP+30 (registers 13, 14 and 15). These are three write cycles back to back, in that order.
- R4: Hardware level L is accepted only when L <= ST[3:0]. Otherwise it gets no acknowledge and causes no memory access, and PC, WP and ST are unchanged.
- R5: After a hardware switch at level L, ST[3:0] equals L-1, or 0 when L is 0. ST[15:4] keeps its old value.
- R6: When several eligible hardware levels are pending, the lowest-numbered one is served.
- R7: A software switch with vector number n reads its pointer pair at byte addresses 0x40+4n and 0x42+4n. ST is left unchanged.
- R8: When requests coincide in `S_IDLE`, an eligible hardware request wins over a software request, and a software request wins over a return.
- R9: A return reloads WP, PC and ST from byte addresses WP+26, WP+28 and WP+30 of the current workspace.
- R10: Acknowledges are single-cycle pulses, and at most one is asserted in any cycle. A switch acknowledges in the sixth cycle after the request is sampled and a return in the fifth. The new register values appear in the cycle after the acknowledge.
- R11: `mem_addr` is the byte address shifted right by one, and WP bit 0 plays no part in word selection. Read data is taken in the cycle after the read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_req | input | 16 | Level-held hardware requests, bit L is level L |
| sw_req | input | 1 | Software context-branch request, held until acknowledged |
| sw_vec | input | 4 | Software vector number |
| rtn_req | input | 1 | Return request, held until acknowledged |
| hw_ack | output | 1 | Hardware switch completed |
| hw_ack_lvl | output | 4 | Level served, valid with hw_ack |
| sw_ack | output | 1 | Software switch completed |
| rtn_ack | output | 1 | Return completed |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 15 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, one cycle after a read |
| pc_o | output | 16 | Current program counter |
| st_o | output | 16 | Current status word |
| wp_o | output | 16 | Current workspace pointer |

## Verification
The assertions check, on every cycle, the following properties:
- At most one acknowledge is asserted.
- A served level never exceeds the mask.
- No lower eligible level is skipped.
- Save writes step through consecutive word addresses.
- The mask takes its new value after a hardware switch.
- ST stays unchanged after a software switch.
- PC and WP never move except at a commit.

Only the bench's scenarios can show the rest:
- The vector and workspace addresses are right.
- The values land in registers 13 to 15 in the stated order.
- Rejected levels cause no memory traffic.
- Return restores the exact earlier state.
- The exact latencies hold.

The bench sweeps every level against every mask value.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_VEC_WP,
        S_VEC_PC,
        S_SAVE_WP,
        S_SAVE_PC,
        S_SAVE_ST,
        S_RET_WP,
        S_RET_PC,
        S_RET_ST,
        S_RET_LAST,
        S_COMMIT
    } cs_state_e;

    typedef enum logic [1:0] {
        OP_HW,
        OP_SW,
        OP_RET
    } cs_op_e;

endpackage

// File: rtl/ctx_prio_pick.sv
module ctx_prio_pick #(
    parameter int NLVL = 16,
    parameter int LW   = $clog2(NLVL)
) (
    input  logic [NLVL-1:0] req,
    input  logic [LW-1:0]   mask,
    output logic            hit,
    output logic [LW-1:0]   lvl
);

    logic [NLVL-1:0] elig;

    generate
        for (genvar i = 0; i < NLVL; i++) begin : g_elig
            assign elig[i] = req[i] && (LW'(i) <= mask);
        end
    endgenerate

    // Scan from the top so the lowest eligible index is the last assignment.
    always_comb begin
        hit = 1'b0;
        lvl = '0;
        for (int i = NLVL - 1; i >= 0; i--) begin
            if (elig[i]) begin
                hit = 1'b1;
                lvl = LW'(i);
            end
        end
    end

endmodule

// File: rtl/ctx_addr_gen.sv
module ctx_addr_gen
    import ctx_pkg::*;
#(
    parameter int DW       = 16,
    parameter int SAVE_IDX = 13
) (
    input  cs_state_e       state,
    input  logic [DW-1:0]   vec_byte,
    input  logic [DW-1:0]   cur_wp,
    input  logic [DW-1:0]   new_wp,
    input  logic [DW-1:0]   cur_pc,
    input  logic [DW-1:0]   cur_st,
    output logic            rd,
    output logic            wr,
    output logic [DW-2:0]   word_addr,
    output logic [DW-1:0]   wdata
);

    localparam int REG_BYTES = DW / 8;
    localparam logic [DW-1:0] OFF_A = DW'(SAVE_IDX * REG_BYTES);
    localparam logic [DW-1:0] OFF_B = DW'((SAVE_IDX + 1) * REG_BYTES);
    localparam logic [DW-1:0] OFF_C = DW'((SAVE_IDX + 2) * REG_BYTES);
    localparam logic [DW-1:0] STEP  = DW'(REG_BYTES);

    logic [DW-1:0] byte_addr;

    always_comb begin
        rd        = 1'b0;
        wr        = 1'b0;
        byte_addr = '0;
        wdata     = '0;
        unique case (state)
            S_VEC_WP:   begin rd = 1'b1; byte_addr = vec_byte;         end
            S_VEC_PC:   begin rd = 1'b1; byte_addr = vec_byte + STEP;  end
            S_SAVE_WP:  begin wr = 1'b1; byte_addr = new_wp + OFF_A; wdata = cur_wp; end
            S_SAVE_PC:  begin wr = 1'b1; byte_addr = new_wp + OFF_B; wdata = cur_pc; end
            S_SAVE_ST:  begin wr = 1'b1; byte_addr = new_wp + OFF_C; wdata = cur_st; end
            S_RET_WP:   begin rd = 1'b1; byte_addr = cur_wp + OFF_A; end
            S_RET_PC:   begin rd = 1'b1; byte_addr = cur_wp + OFF_B; end
            S_RET_ST:   begin rd = 1'b1; byte_addr = cur_wp + OFF_C; end
            S_IDLE, S_RET_LAST, S_COMMIT: begin end
            default:    begin end
        endcase
    end

    assign word_addr = byte_addr[DW-1:1];

endmodule

// File: rtl/ctx_seq.sv
module ctx_seq
    import ctx_pkg::*;
#(
    parameter int              DW       = 16,
    parameter int              LW       = 4,
    parameter int              SAVE_IDX = 13,
    parameter logic [DW-1:0]   HW_BASE  = 16'h0000,
    parameter logic [DW-1:0]   SW_BASE  = 16'h0040
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hw_hit,
    input  logic [LW-1:0]   hw_lvl,
    input  logic            sw_req,
    input  logic [LW-1:0]   sw_vec,
    input  logic            rtn_req,
    output logic            hw_ack,
    output logic [LW-1:0]   hw_ack_lvl,
    output logic            sw_ack,
    output logic            rtn_ack,
    output logic            mem_req,
    output logic            mem_we,
    output logic [DW-2:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    output logic [DW-1:0]   pc_o,
    output logic [DW-1:0]   st_o,
    output logic [DW-1:0]   wp_o
);

    localparam int SLOT_SH = $clog2(2 * (DW / 8));

    cs_state_e     state_q, state_d;
    cs_op_e        op_q;
    logic [LW-1:0] lvl_q;
    logic [DW-1:0] vec_q;
    logic [DW-1:0] tmp_wp, tmp_pc, tmp_st;
    logic [DW-1:0] pc_q, st_q, wp_q;
    logic          rd, wr;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (hw_hit || sw_req) state_d = S_VEC_WP;
                else if (rtn_req)     state_d = S_RET_WP;
            end
            S_VEC_WP:   state_d = S_VEC_PC;
            S_VEC_PC:   state_d = S_SAVE_WP;
            S_SAVE_WP:  state_d = S_SAVE_PC;
            S_SAVE_PC:  state_d = S_SAVE_ST;
            S_SAVE_ST:  state_d = S_COMMIT;
            S_RET_WP:   state_d = S_RET_PC;
            S_RET_PC:   state_d = S_RET_ST;
            S_RET_ST:   state_d = S_RET_LAST;
            S_RET_LAST: state_d = S_COMMIT;
            S_COMMIT:   state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // Outputs decoded from the state.
    always_comb begin
        hw_ack     = (state_q == S_COMMIT) && (op_q == OP_HW);
        sw_ack     = (state_q == S_COMMIT) && (op_q == OP_SW);
        rtn_ack    = (state_q == S_COMMIT) && (op_q == OP_RET);
        hw_ack_lvl = lvl_q;
        mem_req    = rd || wr;
        mem_we     = wr;
    end

    ctx_addr_gen #(.DW(DW), .SAVE_IDX(SAVE_IDX)) u_agen (
        .state     (state_q),
        .vec_byte  (vec_q),
        .cur_wp    (wp_q),
        .new_wp    (tmp_wp),
        .cur_pc    (pc_q),
        .cur_st    (st_q),
        .rd        (rd),
        .wr        (wr),
        .word_addr (mem_addr),
        .wdata     (mem_wdata)
    );

    // Datapath: operation capture, read-data capture, commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_HW;
            lvl_q  <= '0;
            vec_q  <= '0;
            tmp_wp <= '0;
            tmp_pc <= '0;
            tmp_st <= '0;
            pc_q   <= '0;
            st_q   <= '0;
            wp_q   <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (hw_hit) begin
                        op_q  <= OP_HW;
                        lvl_q <= hw_lvl;
                        vec_q <= HW_BASE + (DW'(hw_lvl) << SLOT_SH);
                    end else if (sw_req) begin
                        op_q  <= OP_SW;
                        vec_q <= SW_BASE + (DW'(sw_vec) << SLOT_SH);
                    end else if (rtn_req) begin
                        op_q  <= OP_RET;
                    end
                end
                S_VEC_PC:   tmp_wp <= mem_rdata;
                S_SAVE_WP:  tmp_pc <= mem_rdata;
                S_RET_PC:   tmp_wp <= mem_rdata;
                S_RET_ST:   tmp_pc <= mem_rdata;
                S_RET_LAST: tmp_st <= mem_rdata;
                S_COMMIT: begin
                    wp_q <= tmp_wp;
                    pc_q <= tmp_pc;
                    if (op_q == OP_RET) begin
                        st_q <= tmp_st;
                    end else if (op_q == OP_HW) begin
                        st_q[LW-1:0] <= (lvl_q == '0) ? '0 : lvl_q - 1'b1;
                    end
                end
                default: begin end
            endcase
        end
    end

    assign pc_o = pc_q;
    assign st_o = st_q;
    assign wp_o = wp_q;

    // R3: consecutive save writes walk up one word each cycle.
    a_r3_save_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 1'b1));

    // R5: the mask follows the served level.
    a_r5_mask_update: assert property (@(posedge clk) disable iff (!rst_n)
        hw_ack |=> (st_o[LW-1:0] == (($past(hw_ack_lvl) == '0) ? '0 : $past(hw_ack_lvl) - 1'b1)));

    // R7: a software switch leaves ST alone.
    a_r7_sw_keeps_st: assert property (@(posedge clk) disable iff (!rst_n)
        sw_ack |=> $stable(st_o));

    // R10: registers move only in the cycle after an acknowledge.
    a_r10_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !(hw_ack || sw_ack || rtn_ack) |=> ($stable(wp_o) && $stable(pc_o) && $stable(st_o)));

endmodule

// File: rtl/ctx_switch_unit.sv
module ctx_switch_unit #(
    parameter int            DW       = 16,
    parameter int            NLVL     = 16,
    parameter int            LW       = $clog2(NLVL),
    parameter int            SAVE_IDX = 13,
    parameter logic [DW-1:0] HW_BASE  = 16'h0000,
    parameter logic [DW-1:0] SW_BASE  = 16'h0040
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NLVL-1:0] hw_req,
    input  logic            sw_req,
    input  logic [LW-1:0]   sw_vec,
    input  logic            rtn_req,
    output logic            hw_ack,
    output logic [LW-1:0]   hw_ack_lvl,
    output logic            sw_ack,
    output logic            rtn_ack,
    output logic            mem_req,
    output logic            mem_we,
    output logic [DW-2:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    output logic [DW-1:0]   pc_o,
    output logic [DW-1:0]   st_o,
    output logic [DW-1:0]   wp_o
);

    logic          hw_hit;
    logic [LW-1:0] hw_lvl;

    ctx_prio_pick #(.NLVL(NLVL), .LW(LW)) u_pick (
        .req  (hw_req),
        .mask (st_o[LW-1:0]),
        .hit  (hw_hit),
        .lvl  (hw_lvl)
    );

    ctx_seq #(
        .DW(DW), .LW(LW), .SAVE_IDX(SAVE_IDX),
        .HW_BASE(HW_BASE), .SW_BASE(SW_BASE)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_hit     (hw_hit),
        .hw_lvl     (hw_lvl),
        .sw_req     (sw_req),
        .sw_vec     (sw_vec),
        .rtn_req    (rtn_req),
        .hw_ack     (hw_ack),
        .hw_ack_lvl (hw_ack_lvl),
        .sw_ack     (sw_ack),
        .rtn_ack    (rtn_ack),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .pc_o       (pc_o),
        .st_o       (st_o),
        .wp_o       (wp_o)
    );

    // R10: never two acknowledges together.
    a_r10_one_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hw_ack, sw_ack, rtn_ack}));

    // R4: a served level is always within the mask that gated it.
    a_r4_ack_under_mask: assert property (@(posedge clk) disable iff (!rst_n)
        hw_ack |-> (hw_ack_lvl <= st_o[LW-1:0]));

    // R6: the picker never skips a lower pending eligible level.
    a_r6_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
        hw_hit |-> (hw_req[hw_lvl] &&
                    ((hw_req & ((NLVL'(1) << hw_lvl) - 1'b1)) == '0)));

endmodule

// File: tb/ctx_switch_unit_bench.sv
`timescale 1ns/1ps
module ctx_switch_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] hw_req = '0;
    logic        sw_req = 1'b0;
    logic [3:0]  sw_vec = '0;
    logic        rtn_req = 1'b0;
    logic        hw_ack, sw_ack, rtn_ack, mem_req, mem_we;
    logic [3:0]  hw_ack_lvl;
    logic [14:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata, pc_o, st_o, wp_o;

    always #2 clk = ~clk;

    ctx_switch_unit u_ctx_switch_unit (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .sw_req(sw_req),
        .sw_vec(sw_vec), .rtn_req(rtn_req), .hw_ack(hw_ack),
        .hw_ack_lvl(hw_ack_lvl), .sw_ack(sw_ack), .rtn_ack(rtn_ack),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .pc_o(pc_o), .st_o(st_o), .wp_o(wp_o)
    );

    // Memory model: 1K words, one-cycle read latency, write log.
    logic [15:0] mem [0:1023];
    logic [14:0] wlog_a [0:7];
    logic [15:0] wlog_d [0:7];
    int          wcnt = 0;
    int          rcnt = 0;

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                mem[mem_addr[9:0]] <= mem_wdata;
                wlog_a[wcnt % 8]   <= mem_addr;
                wlog_d[wcnt % 8]   <= mem_wdata;
                wcnt <= wcnt + 1;
            end else begin
                mem_rdata <= mem[mem_addr[9:0]];
                rcnt <= rcnt + 1;
            end
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [15:0] cur_wp, cur_pc, cur_st;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // kind: -1 none, 0 hw, 1 sw, 2 return
    task automatic wait_any(input int limit, output int kind, output int lat, output logic [3:0] lvl);
        kind = -1; lat = 0; lvl = '0;
        for (int k = 1; k <= limit; k++) begin
            @(negedge clk);
            if (hw_ack || sw_ack || rtn_ack) begin
                kind = hw_ack ? 0 : (sw_ack ? 1 : 2);
                lat  = k;
                lvl  = hw_ack_lvl;
                break;
            end
        end
    endtask

    task automatic do_return(input logic [15:0] ewp, input logic [15:0] epc, input logic [15:0] est);
        int kind, lat; logic [3:0] lvl;
        rtn_req = 1'b1;
        wait_any(12, kind, lat, lvl);
        rtn_req = 1'b0;
        chk("R10 return ack kind", 16'(kind), 16'd2);
        chk("R10 return latency", 16'(lat), 16'd5);
        @(negedge clk);
        chk("R9 return wp", wp_o, ewp);
        chk("R9 return pc", pc_o, epc);
        chk("R9 return st", st_o, est);
        cur_wp = wp_o; cur_pc = pc_o; cur_st = st_o;
    endtask

    task automatic set_state(input logic [15:0] wp, input logic [15:0] pc, input logic [15:0] st);
        logic [9:0] b;
        b = 10'(cur_wp >> 1);
        mem[b + 10'd13] <= wp;
        mem[b + 10'd14] <= pc;
        mem[b + 10'd15] <= st;
        do_return(wp, pc, st);
    endtask

    // Runs an accepted switch and checks entry, save area and log.
    task automatic check_switch(input string tag, input logic [15:0] nwp, input logic [15:0] npc,
                                input logic [15:0] nst, input int wbase);
        logic [9:0] b;
        chk({tag, " wp"}, wp_o, nwp);
        chk({tag, " pc"}, pc_o, npc);
        chk({tag, " st"}, st_o, nst);
        b = 10'(nwp >> 1);
        chk("R3 saved wp", mem[b + 10'd13], cur_wp);
        chk("R3 saved pc", mem[b + 10'd14], cur_pc);
        chk("R3 saved st", mem[b + 10'd15], cur_st);
        chk("R3 write count", 16'(wcnt - wbase), 16'd3);
        chk("R3 order r13", 16'(wlog_a[wbase % 8]), 16'(nwp >> 1) + 16'd13);
        chk("R3 order r14", 16'(wlog_a[(wbase + 1) % 8]), 16'(nwp >> 1) + 16'd14);
        chk("R3 order r15", 16'(wlog_a[(wbase + 2) % 8]), 16'(nwp >> 1) + 16'd15);
        chk("R3 order data", wlog_d[(wbase + 2) % 8], cur_st);
    endtask

    function automatic logic [15:0] hw_wp(input int l); return 16'h0300 + 16'(32 * l); endfunction
    function automatic logic [15:0] sw_wp(input int n); return 16'h0500 + 16'(32 * n); endfunction

    initial begin
        int kind, lat, wb, rb;
        logic [3:0]  lvl;
        logic [15:0] owp, opc, ost, exp_st;

        repeat (3) @(negedge clk);
        chk("R1 reset pc", pc_o, 16'h0);
        chk("R1 reset st", st_o, 16'h0);
        chk("R1 reset wp", wp_o, 16'h0);
        chk("R1 reset acks", {13'd0, hw_ack, sw_ack, rtn_ack}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle mem_req", {15'd0, mem_req}, 16'h0);

        cur_wp = 16'h0; cur_pc = 16'h0; cur_st = 16'h0;
        set_state(16'h0200, 16'h0A00, 16'hA5FF);

        // Vector tables (R2, R7, R11: word index = byte address / 2).
        for (int l = 0; l < 16; l++) begin
            mem[10'(2 * l)]     <= hw_wp(l);
            mem[10'(2 * l + 1)] <= 16'h1000 + 16'(l);
            mem[10'(32 + 2 * l)]     <= sw_wp(l);
            mem[10'(32 + 2 * l + 1)] <= 16'h2000 + 16'(l);
        end
        @(negedge clk);

        // Sweep every mask against every level: R2 R3 R4 R5 R9 R10.
        for (int m = 0; m < 16; m++) begin
            for (int l = 0; l < 16; l++) begin
                set_state(16'h0200, 16'h0A00 + 16'(m), 16'hA5F0 | 16'(m));
                owp = cur_wp; opc = cur_pc; ost = cur_st;
                wb = wcnt; rb = rcnt;
                hw_req = 16'(1) << l;
                wait_any(10, kind, lat, lvl);
                hw_req = '0;
                if (l <= m) begin
                    chk("R2 hw ack kind", 16'(kind), 16'd0);
                    chk("R10 hw latency", 16'(lat), 16'd6);
                    chk("R2 hw ack level", 16'(lvl), 16'(l));
                    @(negedge clk);
                    exp_st = (ost & 16'hFFF0) | ((l == 0) ? 16'h0 : 16'(l - 1));
                    check_switch("R2 R5 hw", hw_wp(l), 16'h1000 + 16'(l), exp_st, wb);
                    do_return(owp, opc, ost);
                end else begin
                    chk("R4 masked no ack", 16'(kind + 1), 16'd0);
                    chk("R4 masked no access", 16'((wcnt - wb) + (rcnt - rb)), 16'd0);
                    chk("R4 masked wp", wp_o, owp);
                    chk("R4 masked pc", pc_o, opc);
                    chk("R4 masked st", st_o, ost);
                end
            end
        end

        // R6: many levels pending at once, mask fully open.
        for (int l = 0; l < 16; l++) begin
            set_state(16'h0200, 16'h0B00, 16'h000F);
            hw_req = 16'hFFFF << l;
            if (l < 15) hw_req = hw_req & ~(16'(1) << (l + 1));
            wait_any(10, kind, lat, lvl);
            hw_req = '0;
            chk("R6 lowest level served", 16'(lvl), 16'(l));
            @(negedge clk);
            do_return(16'h0200, 16'h0B00, 16'h000F);
        end
        // R6 with mask 3: levels 2 and 9 pending, 2 wins; 9 and 12 pending, none.
        set_state(16'h0200, 16'h0B10, 16'h0003);
        hw_req = 16'h0204;
        wait_any(10, kind, lat, lvl);
        hw_req = '0;
        chk("R6 masked mix level", 16'(lvl), 16'd2);
        @(negedge clk);
        do_return(16'h0200, 16'h0B10, 16'h0003);
        hw_req = 16'h1200;
        wait_any(10, kind, lat, lvl);
        hw_req = '0;
        chk("R4 R6 all above mask", 16'(kind + 1), 16'd0);

        // R7: every software vector.
        for (int n = 0; n < 16; n++) begin
            set_state(16'h0200, 16'h0C00 + 16'(n), 16'h5A30);
            owp = cur_wp; opc = cur_pc; ost = cur_st;
            wb = wcnt;
            sw_vec = 4'(n); sw_req = 1'b1;
            wait_any(10, kind, lat, lvl);
            sw_req = 1'b0;
            chk("R7 sw ack kind", 16'(kind), 16'd1);
            chk("R10 sw latency", 16'(lat), 16'd6);
            @(negedge clk);
            check_switch("R7 sw", sw_wp(n), 16'h2000 + 16'(n), ost, wb);
            do_return(owp, opc, ost);
        end

        // R8: hardware beats software beats return.
        set_state(16'h0200, 16'h0D00, 16'h000F);
        hw_req = 16'h0020; sw_vec = 4'd3; sw_req = 1'b1; rtn_req = 1'b1;
        wait_any(10, kind, lat, lvl);
        hw_req = '0; sw_req = 1'b0; rtn_req = 1'b0;
        chk("R8 hw wins kind", 16'(kind), 16'd0);
        chk("R8 hw wins level", 16'(lvl), 16'd5);
        @(negedge clk);
        chk("R8 hw wins wp", wp_o, hw_wp(5));
        do_return(16'h0200, 16'h0D00, 16'h000F);
        sw_vec = 4'd7; sw_req = 1'b1; rtn_req = 1'b1;
        wait_any(10, kind, lat, lvl);
        sw_req = 1'b0; rtn_req = 1'b0;
        chk("R8 sw beats return", 16'(kind), 16'd1);
        @(negedge clk);
        chk("R8 sw beats return wp", wp_o, sw_wp(7));
        do_return(16'h0200, 16'h0D00, 16'h000F);

        // R11: an odd WP selects the same words as the even one below it.
        set_state(16'h0201, 16'h0E00, 16'h0000);
        mem[10'h100 + 10'd13] <= 16'h0200;
        mem[10'h100 + 10'd14] <= 16'h0E44;
        mem[10'h100 + 10'd15] <= 16'h0007;
        @(negedge clk);
        do_return(16'h0200, 16'h0E44, 16'h0007);
        chk("R11 odd wp word select", pc_o, 16'h0E44);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule